// File: doc/BRIEF.md
# Strobe-Triggered Bus Snoop Capture Buffer

This block records every byte that a target processor places on its data bus while its I/O chip-select strobe is active. Nothing has to set it up or start it. Each rising edge of the strobe stores one byte in a 256-entry circular store, and the write position moves on by one. A host-side consumer checks an availability flag and pops the bytes in the order they were captured.

The target keeps a small queue descriptor in its own memory: a producer index at base-2 and a consumer index at base-1. The block keeps a copy of the base address, which is zero after reset. Once the base is nonzero, every accepted pop starts a bus-ownership session through a request/grant bus-master port. In that session the new read count is written to base-1, so target software can see how much has been consumed. An initialise command takes ownership once, reads base-2 and writes that value to base-1, which empties the target-side queue. The new base address is stored only after this session ends.

Top module: `snoop_capture_buffer`

## Requirements
- R1: After reset the read count, the write position and the stored base are zero. `avail_o`, `pop_valid_o`, `busy_o` and `mst_req_o` are low.
- R2: `strobe_i` passes through a two-flop synchroniser. Each low-to-high transition stores the `snoop_data_i` value that was stable around the edge, exactly once, however long the strobe stays high.
- R3: The write position runs freely and wraps from 255 to 0. After 256 captures with no pop it equals the read count again, and the oldest entry is overwritten by the next capture.
- R4: `avail_o` is high exactly when the read count differs from the write position.
- R5: A pop is accepted when `pop_i` is high, `avail_o` is high, `busy_o` is low and `init_i` is low. One cycle later `pop_valid_o` pulses for one cycle and `pop_data_o` holds the byte at the read count. The count then goes up by one and wraps from 255 to 0, so bytes come out in capture order.
- R6: A pop with no data available gives `pop_valid_o` low and changes no state.
- R7: If the stored base is nonzero, an accepted pop raises `mst_req_o`. After `mst_gnt_i` it makes exactly one write (`mst_wr_o`) of the new read count to base-1. It then drops the request. `busy_o` stays high until the grant has been withdrawn.
- R8: If the stored base is zero, a pop raises no bus request.
- R9: `init_i` is accepted when `busy_o` is low. Within one ownership session it makes one read at `init_base_i`-2, then one write of the returned byte to `init_base_i`-1. The base is replaced by `init_base_i` only when the session ends. The local read count is left unchanged.
- R10: While `busy_o` is high, `pop_i` and `init_i` are ignored.
- R11: `mst_rd_o` and `mst_wr_o` are never high together, and only while `mst_req_o` and `mst_gnt_i` are both high. A read returns its data through `mst_rdata_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strobe_i | input | 1 | Target I/O chip-select strobe (asynchronous) |
| snoop_data_i | input | DW | Target data bus |
| avail_o | output | 1 | Unread bytes present |
| pop_i | input | 1 | Pop request |
| pop_valid_o | output | 1 | Pop result valid |
| pop_data_o | output | DW | Popped byte |
| init_i | input | 1 | Initialise target-side queue |
| init_base_i | input | AW | Base address used by initialise |
| busy_o | output | 1 | Bus session in progress |
| mst_req_o | output | 1 | Bus ownership request |
| mst_gnt_i | input | 1 | Bus ownership grant |
| mst_rd_o | output | 1 | Read access strobe |
| mst_wr_o | output | 1 | Write access strobe |
| mst_addr_o | output | AW | Access address |
| mst_wdata_o | output | DW | Write data |
| mst_rdata_i | input | DW | Read data |

## Verification
Two situations are hard to reach from the ports. The first is a wrapped write position: the store then looks empty while holding 256 bytes. The second is the read count crossing 255 to 0. The stimulus fills the store with 256 captures without popping, checks that `avail_o` is low, adds one more capture, and then runs a long loop of captures and pops that carries the read count past its wrap. Pops and initialise commands that arrive during a session are checked with a grant model that holds off for several cycles, so both requests can be pulsed while `busy_o` is high.

// File: rtl/snoop_capture_buffer.sv
module snoop_capture_buffer #(
  parameter int DW    = 8,
  parameter int PTR_W = 8,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_i,
  input  logic [DW-1:0] snoop_data_i,
  output logic          avail_o,
  input  logic          pop_i,
  output logic          pop_valid_o,
  output logic [DW-1:0] pop_data_o,
  input  logic          init_i,
  input  logic [AW-1:0] init_base_i,
  output logic          busy_o,
  output logic          mst_req_o,
  input  logic          mst_gnt_i,
  output logic          mst_rd_o,
  output logic          mst_wr_o,
  output logic [AW-1:0] mst_addr_o,
  output logic [DW-1:0] mst_wdata_o,
  input  logic [DW-1:0] mst_rdata_i
);
  localparam int DEPTH = 1 << PTR_W;
  localparam logic [AW-1:0] PROD_OFS = AW'(2);
  localparam logic [AW-1:0] CONS_OFS = AW'(1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_REL} state_t;

  logic [DW-1:0]    store [DEPTH];
  logic [2:0]       sync_q;
  logic [DW-1:0]    dat0_q, dat1_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [AW-1:0]    base_q, op_base_q;
  logic [DW-1:0]    xfer_q;
  logic             op_init_q;
  state_t           state_q;

  wire capture  = sync_q[1] & ~sync_q[2];
  wire idle     = (state_q == S_IDLE);
  wire pop_ok   = pop_i & avail_o & idle & ~init_i;
  wire init_ok  = init_i & idle;
  wire [PTR_W-1:0] rd_next = rd_q + 1'b1;

  assign avail_o     = (rd_q != wr_q);
  assign busy_o      = ~idle;
  assign mst_req_o   = (state_q == S_REQ) | (state_q == S_RD) | (state_q == S_WR);
  assign mst_rd_o    = (state_q == S_RD);
  assign mst_wr_o    = (state_q == S_WR);
  assign mst_addr_o  = mst_rd_o ? op_base_q - PROD_OFS : op_base_q - CONS_OFS;
  assign mst_wdata_o = xfer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      dat0_q <= '0;
      dat1_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], strobe_i};
      dat0_q <= snoop_data_i;
      dat1_q <= dat0_q;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) store[wr_q] <= dat1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (capture) begin
      wr_q <= wr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q        <= '0;
      pop_valid_o <= 1'b0;
      pop_data_o  <= '0;
    end else begin
      pop_valid_o <= pop_ok;
      if (pop_ok) begin
        pop_data_o <= store[rd_q];
        rd_q       <= rd_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      base_q    <= '0;
      op_base_q <= '0;
      xfer_q    <= '0;
      op_init_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (init_ok) begin
            op_base_q <= init_base_i;
            op_init_q <= 1'b1;
            state_q   <= S_REQ;
          end else if (pop_ok && base_q != '0) begin
            op_base_q <= base_q;
            op_init_q <= 1'b0;
            xfer_q    <= DW'(rd_next);
            state_q   <= S_REQ;
          end
        end
        S_REQ: if (mst_gnt_i) state_q <= op_init_q ? S_RD : S_WR;
        S_RD: begin
          xfer_q  <= mst_rdata_i;
          state_q <= S_WR;
        end
        S_WR: state_q <= S_REL;
        S_REL: begin
          if (!mst_gnt_i) begin
            if (op_init_q) base_q <= op_base_q;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  capture_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (wr_q == $past(wr_q) + 1'b1));

  // R5
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (pop_valid_o && rd_q == $past(rd_q) + 1'b1));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !avail_o) |=> (!pop_valid_o && $stable(rd_q)));

  // R8
  no_base_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && base_q == '0 && !init_i) |=> !mst_req_o);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && pop_i) |=> !pop_valid_o);

  // R11
  access_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_rd_o || mst_wr_o) |-> (mst_req_o && mst_gnt_i));

  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mst_rd_o, mst_wr_o}));
endmodule

// File: tb/snoop_capture_buffer_bench.sv
module snoop_capture_buffer_bench;
  localparam int DW = 8, PTR_W = 8, AW = 16;

  logic clk = 0, rst_n = 0;
  logic strobe = 0, pop = 0, init = 0, gnt = 0;
  logic [DW-1:0] sdata = 0;
  logic [AW-1:0] ibase = 0;
  wire avail, pvalid, busy, req, mrd, mwr;
  wire [DW-1:0] pdata, wdata, rdata;
  wire [AW-1:0] addr;

  always #4 clk = ~clk;

  snoop_capture_buffer #(.DW(DW), .PTR_W(PTR_W), .AW(AW)) u_snoop_capture_buffer (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .snoop_data_i(sdata),
    .avail_o(avail), .pop_i(pop), .pop_valid_o(pvalid), .pop_data_o(pdata),
    .init_i(init), .init_base_i(ibase), .busy_o(busy),
    .mst_req_o(req), .mst_gnt_i(gnt), .mst_rd_o(mrd), .mst_wr_o(mwr),
    .mst_addr_o(addr), .mst_wdata_o(wdata), .mst_rdata_i(rdata));

  logic [DW-1:0] tmem [1 << AW];
  logic poke_en = 0;
  logic [AW-1:0] poke_a = 0;
  logic [DW-1:0] poke_d = 0;
  int n_wr = 0, n_rd = 0, n_req = 0, bad_acc = 0;
  logic [AW-1:0] last_wa = 0, last_ra = 0;
  logic req_d = 0;
  int gdly = 0;
  assign rdata = tmem[addr];

  always @(posedge clk) begin
    if (poke_en) tmem[poke_a] <= poke_d;
    if (mwr) begin tmem[addr] <= wdata; n_wr <= n_wr + 1; last_wa <= addr; end
    if (mrd) begin n_rd <= n_rd + 1; last_ra <= addr; end
    if ((mrd || mwr) && !(gnt && req)) bad_acc <= bad_acc + 1;
    if ((mrd && mwr)) bad_acc <= bad_acc + 1;
    req_d <= req;
    if (req && !req_d) n_req <= n_req + 1;
    if (!req) begin gdly <= 0; gnt <= 0; end
    else if (gdly == 3) gnt <= 1;
    else gdly <= gdly + 1;
  end

  int checks = 0, errors = 0;
  logic [7:0] exp_rd = 0;
  logic [7:0] seq = 8'h10;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); poke_en = 1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic capture(input logic [DW-1:0] d, input int hold);
    @(negedge clk); sdata = d; strobe = 1;
    repeat (hold) @(negedge clk);
    strobe = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_pop(output logic v, output logic [DW-1:0] d);
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0; v = pvalid; d = pdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  task automatic pop_expect(input string tag, input logic [DW-1:0] e);
    logic v; logic [DW-1:0] d;
    do_pop(v, d);
    chk({tag, " valid"}, v, 1);
    chk({tag, " data"}, d, e);
    exp_rd = exp_rd + 1;
    wait_idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 avail", avail, 0);
    chk("R1 pvalid", pvalid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req", req, 0);
  endtask

  task automatic t_basic();
    capture(8'hA1, 4); capture(8'hB2, 4); capture(8'hC3, 4);
    chk("R4 avail after capture", avail, 1);
    pop_expect("R5 first", 8'hA1);
    pop_expect("R5 second", 8'hB2);
    pop_expect("R5 third", 8'hC3);
    chk("R4 avail drained", avail, 0);
    chk("R8 no request with zero base", n_req, 0);
  endtask

  task automatic t_long_strobe();
    capture(8'h5C, 30);
    pop_expect("R2 long strobe", 8'h5C);
    chk("R2 single capture", avail, 0);
  endtask

  task automatic t_empty_pop();
    logic v; logic [DW-1:0] d;
    do_pop(v, d);
    chk("R6 empty pop invalid", v, 0);
    chk("R6 still empty", avail, 0);
    capture(8'h77, 4);
    pop_expect("R6 state kept", 8'h77);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 256; i++) capture(8'(i ^ 8'h3C), 3);
    chk("R3 full wrap looks empty", avail, 0);
    capture(8'hEE, 3);
    chk("R3 avail after extra", avail, 1);
    pop_expect("R3 overwrite oldest", 8'hEE);
    for (int i = 0; i < 260; i++) begin
      capture(seq, 3);
      pop_expect("R5 read wrap order", seq);
      seq = seq + 8'd7;
    end
    chk("R4 empty after wrap loop", avail, 0);
  endtask

  task automatic t_init();
    int r0, w0;
    poke(16'h01FE, 8'h37);
    poke(16'h01FF, 8'h05);
    r0 = n_rd; w0 = n_wr;
    @(negedge clk); ibase = 16'h0200; init = 1;
    @(negedge clk); init = 0;
    chk("R9 busy during init", busy, 1);
    wait_idle();
    chk("R9 one read", n_rd - r0, 1);
    chk("R9 read addr", last_ra, 16'h01FE);
    chk("R9 one write", n_wr - w0, 1);
    chk("R9 consumer index", tmem[16'h01FF], 8'h37);
    chk("R9 local count kept", avail, 0);
    capture(8'h9D, 4);
    w0 = n_wr;
    pop_expect("R7 pop with base", 8'h9D);
    chk("R7 one writeback", n_wr - w0, 1);
    chk("R7 writeback addr", last_wa, 16'h01FF);
    chk("R7 writeback value", tmem[16'h01FF], exp_rd);
    chk("R7 request released", req, 0);
  endtask

  task automatic t_busy_ignore();
    logic v; logic [DW-1:0] d;
    int r0;
    capture(8'h41, 4); capture(8'h42, 4);
    do_pop(v, d);
    chk("R7 pop valid", v, 1);
    chk("R7 pop data", d, 8'h41);
    exp_rd = exp_rd + 1;
    chk("R7 busy after pop", busy, 1);
    r0 = n_rd;
    do_pop(v, d);
    chk("R10 pop ignored while busy", v, 0);
    @(negedge clk); ibase = 16'h0300; init = 1;
    @(negedge clk); init = 0;
    wait_idle();
    chk("R10 init ignored while busy", n_rd - r0, 0);
    chk("R10 base unchanged", last_wa, 16'h01FF);
    pop_expect("R10 pending byte kept", 8'h42);
    chk("R7 base still old", last_wa, 16'h01FF);
    chk("R11 accesses only when owned", bad_acc, 0);
  endtask

  logic done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_long_strobe();
    t_empty_pop();
    t_wrap();
    t_init();
    t_busy_ignore();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule